// File: doc/BRIEF.md
# Serial-Bus Controller Event, Mask and Command Front End

This block sits between a small register bus and the transfer engine of a two-wire serial bus controller. It keeps a sticky event register, an interrupt mask register and a command register. The transfer engine reports four conditions as one-cycle pulses: a transmit error, a received byte discarded because no receive buffer was free, the final character of a transmit buffer shifted out, and a receive buffer closed. Each pulse sets its own event bit. Software clears a bit by writing a 1 to it. A single interrupt line stays high while any event bit is both set and enabled in the mask.

The command register holds a mode bit and a start strobe that clears itself. In master mode the strobe asks the engine to start a transfer at once, provided a transmit buffer is ready. In slave mode the strobe only arms the block. It preloads the transmit data register, and the actual send is released later, when the engine reports an address byte that matches the slave address with the read direction. Arming is lost if the mode bit changes before that match arrives.

Top module: `i2c_rf_top`

## Requirements
- R1: Each engine pulse sets one event bit, with bits numbered from the LSB. A transmit error sets bit 4 (0x10). A discarded receive byte sets bit 2 (0x04). Transmit-buffer done sets bit 1 (0x02). Receive-buffer closed sets bit 0 (0x01). Bits 7:5 and 3 always read 0. The event register is at bus address 0.
- R2: Event bits are sticky. Writing 1 to a bit at address 0 clears it. Writing 0, or writing to reserved bits, changes nothing.
- R3: If an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends set.
- R4: The mask register is at address 1 and uses the same layout as the event register. Its reserved bits read 0, and a mask bit of 1 enables that event. `irq` is high exactly while some event bit is set and enabled. It stays high until every such bit has been cleared or masked. `irq` changes in the same cycle as the register that causes the change.
- R5: The active-low asynchronous `rst_n` and the synchronous `soft_rst` each return the event, mask and command registers to 0x00. They also drive `irq`, `slave_armed` and every pulse output low.
- R6: The command register is at address 2. Bit 0 selects master (1) or slave (0) and reads back as written. Bit 7 is the start strobe and always reads 0. All other command bits read 0. Reads from address 3 return 0.
- R7: A command write with bit 7 = 1 and bit 0 = 1 while `tx_buf_ready` is high pulses `start_req` for one cycle, starting the cycle after the write. If `tx_buf_ready` is low, no pulse is produced.
- R8: A command write with bit 7 = 1 and bit 0 = 0 while `engine_idle` and `tx_buf_ready` are both high pulses `tx_preload` for one cycle and sets `slave_armed`. An `addr_rd_match` pulse while armed gives a one-cycle `slave_send` pulse in the next cycle and clears `slave_armed`.
- R9: A slave-mode start strobe written while `engine_idle` is low, or while `tx_buf_ready` is low, is ignored. No `tx_preload` pulse is produced and `slave_armed` stays low.
- R10: A command write that changes the mode bit clears `slave_armed`. A later `addr_rd_match` then produces no `slave_send`.
- R11: An `addr_rd_match` pulse while not armed produces no `slave_send`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from bus_addr) |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_rx_drop | input | 1 | Received byte discarded pulse |
| ev_tx_last | input | 1 | Last transmit character sent pulse |
| ev_rx_close | input | 1 | Receive buffer closed pulse |
| tx_buf_ready | input | 1 | A transmit buffer is ready |
| engine_idle | input | 1 | Transfer engine is idle |
| addr_rd_match | input | 1 | Matching slave address with read direction seen |
| irq | output | 1 | Interrupt request |
| start_req | output | 1 | Master transfer start pulse |
| mode_master | output | 1 | Current mode, 1 = master |
| tx_preload | output | 1 | Slave transmit data preload pulse |
| slave_armed | output | 1 | Slave transmit armed, waiting for match |
| slave_send | output | 1 | Slave send release pulse |

## Verification
The hardest case to reach is the race between an incoming event pulse and a software clear of the same bit. The bench holds the error pulse and a write-1 clear on the bus in one cycle, clears a second bit in that same write, and checks that only the racing bit survives. The slave path needs an ordered sequence to reach its corner: switch to slave mode, arm with the engine idle, then either deliver the match or flip the mode bit before it. The bench also repeats the strobe with the engine busy, and then with no buffer ready, to show the strobe is dropped in both cases.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    localparam int REG_W  = 8;
    localparam int NUM_EV = 4;

    // event bit positions, LSB numbering; software decodes these
    localparam int EVB_TXERR   = 4;
    localparam int EVB_DROP    = 2;
    localparam int EVB_TXLAST  = 1;
    localparam int EVB_RXCLOSE = 0;
    localparam logic [REG_W-1:0] EV_VALID = 8'h17;

    localparam int CMDB_START = 7;
    localparam int CMDB_MODE  = 0;

    // source index -> register bit
    function automatic int ev_pos(input int idx);
        case (idx)
            0:       ev_pos = EVB_TXERR;
            1:       ev_pos = EVB_DROP;
            2:       ev_pos = EVB_TXLAST;
            default: ev_pos = EVB_RXCLOSE;
        endcase
    endfunction
endpackage

// File: rtl/i2c_rf_events.sv
module i2c_rf_events
    import i2c_rf_pkg::*;
#(
    parameter int W    = REG_W,
    parameter int NSRC = NUM_EV
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_rst,
    input  logic [NSRC-1:0] src,
    input  logic           wr_evt,
    input  logic           wr_msk,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   evt_val,
    output logic [W-1:0]   msk_val,
    output logic           irq
);
    typedef struct packed {
        logic [W-1:0] evt;
        logic [W-1:0] msk;
        logic         irq;
    } ev_state_t;

    localparam logic [W-1:0] VALID = W'(EV_VALID);

    ev_state_t st_d, st_q;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            set_vec[ev_pos(i)] = set_vec[ev_pos(i)] | src[i];
        end
        clr_vec = wr_evt ? (wdata & VALID) : '0;

        st_d     = st_q;
        st_d.evt = ((st_q.evt & ~clr_vec) | set_vec) & VALID;
        if (wr_msk) begin
            st_d.msk = wdata & VALID;
        end
        st_d.irq = |(st_d.evt & st_d.msk);
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_val = st_q.evt;
    assign msk_val = st_q.msk;
    assign irq     = st_q.irq;
endmodule

// File: rtl/i2c_rf_command.sv
module i2c_rf_command (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr_cmd,
    input  logic wr_start,
    input  logic wr_mode,
    input  logic tx_buf_ready,
    input  logic engine_idle,
    input  logic addr_rd_match,
    output logic mode_master,
    output logic start_req,
    output logic tx_preload,
    output logic slave_armed,
    output logic slave_send
);
    typedef struct packed {
        logic master;
        logic start;
        logic preload;
        logic armed;
        logic send;
    } cmd_state_t;

    cmd_state_t st_d, st_q;
    logic       mode_new;
    logic       strobe;

    always_comb begin
        st_d         = st_q;
        st_d.start   = 1'b0;
        st_d.preload = 1'b0;
        st_d.send    = 1'b0;

        mode_new = wr_cmd ? wr_mode : st_q.master;
        strobe   = wr_cmd & wr_start & tx_buf_ready;

        if (wr_cmd) begin
            st_d.master = wr_mode;
        end

        // release of an armed slave transmit
        if (st_q.armed && addr_rd_match) begin
            st_d.send  = 1'b1;
            st_d.armed = 1'b0;
        end

        // mode flip drops a pending arm
        if (wr_cmd && (wr_mode != st_q.master)) begin
            st_d.armed = 1'b0;
        end

        if (strobe) begin
            if (mode_new) begin
                st_d.start = 1'b1;
            end else if (engine_idle) begin
                st_d.preload = 1'b1;
                st_d.armed   = 1'b1;
            end
        end

        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_master = st_q.master;
    assign start_req   = st_q.start;
    assign tx_preload  = st_q.preload;
    assign slave_armed = st_q.armed;
    assign slave_send  = st_q.send;
endmodule

// File: rtl/i2c_rf_top.sv
module i2c_rf_top
    import i2c_rf_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ev_tx_err,
    input  logic              ev_rx_drop,
    input  logic              ev_tx_last,
    input  logic              ev_rx_close,
    input  logic              tx_buf_ready,
    input  logic              engine_idle,
    input  logic              addr_rd_match,
    output logic              irq,
    output logic              start_req,
    output logic              mode_master,
    output logic              tx_preload,
    output logic              slave_armed,
    output logic              slave_send
);
    localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(2);

    logic              wr_hit;
    logic              wr_evt, wr_msk, wr_cmd;
    logic [REG_W-1:0]  evt_val, msk_val;
    logic [NUM_EV-1:0] ev_src;

    assign wr_hit = bus_sel & bus_wr;
    assign wr_evt = wr_hit & (bus_addr == A_EVT);
    assign wr_msk = wr_hit & (bus_addr == A_MSK);
    assign wr_cmd = wr_hit & (bus_addr == A_CMD);
    assign ev_src = {ev_rx_close, ev_tx_last, ev_rx_drop, ev_tx_err};

    i2c_rf_events #(.W(REG_W), .NSRC(NUM_EV)) u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .src     (ev_src),
        .wr_evt  (wr_evt),
        .wr_msk  (wr_msk),
        .wdata   (bus_wdata),
        .evt_val (evt_val),
        .msk_val (msk_val),
        .irq     (irq)
    );

    i2c_rf_command u_command (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .wr_cmd       (wr_cmd),
        .wr_start     (bus_wdata[CMDB_START]),
        .wr_mode      (bus_wdata[CMDB_MODE]),
        .tx_buf_ready (tx_buf_ready),
        .engine_idle  (engine_idle),
        .addr_rd_match(addr_rd_match),
        .mode_master  (mode_master),
        .start_req    (start_req),
        .tx_preload   (tx_preload),
        .slave_armed  (slave_armed),
        .slave_send   (slave_send)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_EVT) begin
            bus_rdata = evt_val;
        end else if (bus_addr == A_MSK) begin
            bus_rdata = msk_val;
        end else if (bus_addr == A_CMD) begin
            bus_rdata[CMDB_MODE] = mode_master;
        end
    end
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              ev_tx_err,
    input logic              tx_buf_ready,
    input logic              engine_idle,
    input logic              addr_rd_match,
    input logic              irq,
    input logic              start_req,
    input logic              mode_master,
    input logic              tx_preload,
    input logic              slave_armed,
    input logic              slave_send,
    input logic [7:0]        evt_val,
    input logic [7:0]        msk_val
);
    logic w_evt, w_msk, w_cmd;
    assign w_evt = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign w_msk = bus_sel && bus_wr && (bus_addr == ADDR_W'(1));
    assign w_cmd = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));

    // R1
    evt_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> ((bus_rdata & 8'hE8) == 8'h00));

    // R2
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_evt && !soft_rst) |=> ((evt_val & $past(evt_val)) == $past(evt_val)));

    // R3
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_err && !soft_rst) |=> evt_val[4]);

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !w_evt && !w_msk && !soft_rst) |=> irq);

    // R5
    soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (evt_val == 8'h00 && msk_val == 8'h00 && !mode_master
                      && !slave_armed && !irq && !start_req));

    // R6
    start_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(2)) |-> (bus_rdata[7:1] == 7'd0));

    // R7
    start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> $past(w_cmd && bus_wdata[7] && bus_wdata[0] && tx_buf_ready));

    // R8
    send_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_send |-> $past(slave_armed && addr_rd_match));

    // R9
    preload_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_preload |-> $past(engine_idle && tx_buf_ready && w_cmd && !bus_wdata[0]));

    // R10
    mode_flip_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_cmd && !bus_wdata[7] && (bus_wdata[0] != mode_master)) |=> !slave_armed);
endmodule

bind i2c_rf_top i2c_rf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ev_tx_err    (ev_tx_err),
    .tx_buf_ready (tx_buf_ready),
    .engine_idle  (engine_idle),
    .addr_rd_match(addr_rd_match),
    .irq          (irq),
    .start_req    (start_req),
    .mode_master  (mode_master),
    .tx_preload   (tx_preload),
    .slave_armed  (slave_armed),
    .slave_send   (slave_send),
    .evt_val      (evt_val),
    .msk_val      (msk_val)
);

// File: tb/i2c_rf_top_tb.sv
module i2c_rf_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          ev_tx_err = 1'b0, ev_rx_drop = 1'b0, ev_tx_last = 1'b0, ev_rx_close = 1'b0;
    logic          tx_buf_ready = 1'b0, engine_idle = 1'b0, addr_rd_match = 1'b0;
    logic          irq, start_req, mode_master, tx_preload, slave_armed, slave_send;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_rf_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tx_err(ev_tx_err), .ev_rx_drop(ev_rx_drop),
        .ev_tx_last(ev_tx_last), .ev_rx_close(ev_rx_close),
        .tx_buf_ready(tx_buf_ready), .engine_idle(engine_idle),
        .addr_rd_match(addr_rd_match), .irq(irq), .start_req(start_req),
        .mode_master(mode_master), .tx_preload(tx_preload),
        .slave_armed(slave_armed), .slave_send(slave_send)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // order: {tx_err, rx_drop, tx_last, rx_close}
    task automatic pulse_ev(input logic [3:0] v);
        @(negedge clk);
        {ev_tx_err, ev_rx_drop, ev_tx_last, ev_rx_close} = v;
        @(negedge clk);
        {ev_tx_err, ev_rx_drop, ev_tx_last, ev_rx_close} = '0;
    endtask

    task automatic pulse_match();
        @(negedge clk);
        addr_rd_match = 1'b1;
        @(negedge clk);
        addr_rd_match = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(0, v); chk("R5 evt after reset", v, 8'h00);
        rd(1, v); chk("R5 msk after reset", v, 8'h00);
        rd(2, v); chk("R5 cmd after reset", v, 8'h00);
        chk("R5 irq after reset", {7'd0, irq}, 8'h00);
        chk("R5 armed after reset", {7'd0, slave_armed}, 8'h00);
    endtask

    task automatic t_events();
        logic [7:0] v;
        pulse_ev(4'b1000); rd(0, v); chk("R1 tx error bit4", v, 8'h10);
        pulse_ev(4'b0100); rd(0, v); chk("R1 discard bit2", v, 8'h14);
        pulse_ev(4'b0010); rd(0, v); chk("R1 tx done bit1", v, 8'h16);
        pulse_ev(4'b0001); rd(0, v); chk("R1 rx closed bit0", v, 8'h17);
        chk("R4 masked events no irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        wr(0, 8'h00); rd(0, v); chk("R2 write zero keeps", v, 8'h17);
        wr(0, 8'hE8); rd(0, v); chk("R2 reserved write keeps", v, 8'h17);
        wr(0, 8'h02); rd(0, v); chk("R2 clear bit1 only", v, 8'h15);
        wr(0, 8'hFF); rd(0, v); chk("R2 clear all", v, 8'h00);
    endtask

    task automatic t_race();
        logic [7:0] v;
        pulse_ev(4'b0001);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 0; bus_wdata = 8'h11;
        ev_tx_err = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ev_tx_err = 1'b0;
        rd(0, v); chk("R3 set wins, other bit cleared", v, 8'h10);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(1, 8'hFF); rd(1, v); chk("R4 mask reserved read zero", v, 8'h17);
        chk("R4 irq on unmasked", {7'd0, irq}, 8'h01);
        wr(1, 8'h01); chk("R4 irq off when masked", {7'd0, irq}, 8'h00);
        pulse_ev(4'b0001); chk("R4 irq on new event", {7'd0, irq}, 8'h01);
        @(negedge clk); chk("R4 irq holds", {7'd0, irq}, 8'h01);
        wr(0, 8'h01); chk("R4 irq off after clear", {7'd0, irq}, 8'h00);
        wr(0, 8'h10); rd(0, v); chk("R2 cleanup", v, 8'h00);
    endtask

    task automatic t_cmd_read();
        logic [7:0] v;
        tx_buf_ready = 1'b0;
        wr(2, 8'h81);
        chk("R7 no start without buffer", {7'd0, start_req}, 8'h00);
        rd(2, v); chk("R6 start reads zero", v, 8'h01);
        wr(2, 8'hFE); rd(2, v); chk("R6 mode slave readback", v, 8'h00);
        rd(3, v); chk("R6 unused address", v, 8'h00);
    endtask

    task automatic t_master();
        tx_buf_ready = 1'b1;
        wr(2, 8'h81);
        chk("R7 start pulse", {7'd0, start_req}, 8'h01);
        @(negedge clk); chk("R7 start one cycle", {7'd0, start_req}, 8'h00);
        wr(2, 8'h01); chk("R7 no strobe no start", {7'd0, start_req}, 8'h00);
    endtask

    task automatic t_slave();
        tx_buf_ready = 1'b1; engine_idle = 1'b1;
        wr(2, 8'h00);
        wr(2, 8'h80);
        chk("R8 preload pulse", {7'd0, tx_preload}, 8'h01);
        chk("R8 armed", {7'd0, slave_armed}, 8'h01);
        chk("R8 no master start", {7'd0, start_req}, 8'h00);
        @(negedge clk);
        chk("R8 preload one cycle", {7'd0, tx_preload}, 8'h00);
        chk("R8 send waits for match", {7'd0, slave_send}, 8'h00);
        pulse_match();
        chk("R8 send on match", {7'd0, slave_send}, 8'h01);
        chk("R8 disarm on match", {7'd0, slave_armed}, 8'h00);
        @(negedge clk); chk("R8 send one cycle", {7'd0, slave_send}, 8'h00);
    endtask

    task automatic t_slave_busy();
        engine_idle = 1'b0; tx_buf_ready = 1'b1;
        wr(2, 8'h80);
        chk("R9 busy no preload", {7'd0, tx_preload}, 8'h00);
        chk("R9 busy not armed", {7'd0, slave_armed}, 8'h00);
        engine_idle = 1'b1; tx_buf_ready = 1'b0;
        wr(2, 8'h80);
        chk("R9 no buffer no preload", {7'd0, tx_preload}, 8'h00);
        chk("R9 no buffer not armed", {7'd0, slave_armed}, 8'h00);
    endtask

    task automatic t_mode_drop();
        engine_idle = 1'b1; tx_buf_ready = 1'b1;
        wr(2, 8'h80);
        chk("R10 armed first", {7'd0, slave_armed}, 8'h01);
        wr(2, 8'h01);
        chk("R10 mode flip disarms", {7'd0, slave_armed}, 8'h00);
        pulse_match();
        chk("R10 no send after flip", {7'd0, slave_send}, 8'h00);
        wr(2, 8'h00);
    endtask

    task automatic t_nomatch();
        pulse_match();
        chk("R11 match unarmed no send", {7'd0, slave_send}, 8'h00);
    endtask

    task automatic t_soft();
        logic [7:0] v;
        pulse_ev(4'b1111);
        wr(1, 8'h17);
        wr(2, 8'h01);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        rd(0, v); chk("R5 soft evt", v, 8'h00);
        rd(1, v); chk("R5 soft msk", v, 8'h00);
        rd(2, v); chk("R5 soft cmd", v, 8'h00);
        chk("R5 soft irq", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_race();
        t_mask();
        t_cmd_read();
        t_master();
        t_slave();
        t_slave_busy();
        t_mode_drop();
        t_nomatch();
        t_soft();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule